// File: doc/BRIEF.md
# Program ROM Bank Translator

This block turns a CPU address into a physical byte address for a banked program ROM, and also marks accesses to a small work RAM window. The CPU sees a 32 KiB program space from 0x8000 to 0xFFFF. The ROM behind that space holds `BANKS16` banks of 16 KiB each, where `BANKS16` is a power of two. A two-bit mode input and a five-bit bank register decide which 16 KiB ROM bank appears in each half of the program space. The lower half is 0x8000–0xBFFF and the upper half is 0xC000–0xFFFF.

For large ROMs, bit 4 of the bank register confines all banking to one half of the ROM, and bit 3 picks that half. This applies to every mode, including the fixed-bank modes. An 8 KiB RAM window at 0x6000–0x7FFF produces a RAM select and a 13-bit offset. The ROM and RAM arrays themselves sit outside the block.

The outputs can be registered (`REG_OUT=1`) or purely combinational (`REG_OUT=0`).

Top module: `prg_rom_bank_xlat`

## Requirements
- R1: `rom_sel` is 1 exactly when `cpu_addr` is at or above 0x8000. `ram_sel` is 1 exactly for 0x6000–0x7FFF, with `ram_offset` equal to `cpu_addr[12:0]`. Below 0x6000 neither select is 1. Whenever `rom_sel` is 0, `rom_addr` is zero, and whenever `ram_sel` is 0, `ram_offset` is zero.
- R2: `rom_addr` is formed as the bank number times 16 KiB plus `cpu_addr[13:0]`. The bank number occupies the bits above bit 13.
- R3: In modes 0 and 1 (`ctrl_mode` = 00 or 01), the whole 32 KiB is switched. The bank number is `prg_bank[4:1]` times two, plus one when `cpu_addr` is 0xC000 or above.
- R4: In mode 2 (`ctrl_mode` = 10), the lower half maps to bank 0 and the upper half maps to bank `prg_bank[3:0]`.
- R5: In mode 3 (`ctrl_mode` = 11), the lower half maps to bank `prg_bank[3:0]` and the upper half maps to the last bank.
- R6: Without the half override, the bank number wraps modulo `BANKS16`.
- R7: When `prg_bank[4]` is 1 and `BANKS16` is greater than 8, the half override is active. The bank number is taken modulo `BANKS16/2`, and `prg_bank[3]` times `BANKS16/2` is added to it. In this case the "last bank" of mode 3 is `BANKS16/2-1`, and it is taken before the half base is added.
- R8: When `BANKS16` is 8 or less, `prg_bank[4]` never triggers the override. The last bank is `BANKS16-1`, and the fixed bank 0 of mode 2 stays bank 0.
- R9: With `REG_OUT=1`, all outputs show the result for the inputs sampled at the previous rising clock edge. A low `rst_n` at a clock edge clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Synchronous active-low reset of the output register |
| cpu_addr | input | 16 | CPU address |
| ctrl_mode | input | 2 | Banking mode (0–3) |
| prg_bank | input | 5 | Program bank register; bit 4 enables the half override, bit 3 selects the half |
| rom_sel | output | 1 | ROM window hit |
| rom_addr | output | log2(BANKS16)+14 | Physical ROM byte address |
| ram_sel | output | 1 | Work RAM window hit |
| ram_offset | output | 13 | Byte offset into the work RAM |

## Verification
The bench builds two instances.

The main one has `BANKS16=16` and `REG_OUT=1`. At 16 banks the half override is live. This makes it possible to see the override lifting the fixed bank 0 to bank 8 and pulling the fixed last bank down to 7, and to check the one-cycle latency and the reset clearing of the outputs.

The second instance has `BANKS16=8` and `REG_OUT=0`. Its register values exceed the bank count, so it exposes modulo wrapping. It also shows that bit 4 of the bank register does nothing on a small ROM.

// File: rtl/prg_xlat_pkg.sv
// Shared types for the program ROM bank translator.
// The banking mode encoding is fixed by the control register layout.
package prg_xlat_pkg;

    typedef enum logic [1:0] {
        MODE_W32A     = 2'd0,  // 32 KiB switched
        MODE_W32B     = 2'd1,  // 32 KiB switched (same behaviour)
        MODE_FIX_LOW  = 2'd2,  // lower half fixed to bank 0
        MODE_FIX_HIGH = 2'd3   // upper half fixed to the last bank
    } bank_mode_e;

endpackage

// File: rtl/prg_window_decode.sv
// Address window decoder.
// Classifies a CPU address as ROM (0x8000 and above), work RAM (0x6000-0x7FFF)
// or neither, and flags the upper 16 KiB half of the ROM window.
// Assumes a 16-bit CPU address.
module prg_window_decode (
    input  logic [15:0] cpu_addr,
    output logic        rom_hit,
    output logic        ram_hit,
    output logic        upper_half
);

    // Window classification from the top address bits.
    always_comb begin
        rom_hit    = cpu_addr[15];
        ram_hit    = (cpu_addr[15:13] == 3'b011);
        upper_half = cpu_addr[14];
    end

endmodule

// File: rtl/prg_bank_select.sv
// Mode-driven bank selection.
// Chooses the raw 16 KiB bank number from the banking mode, the bank register
// and the half of the window being accessed. The result is then reduced
// modulo BANKS16.
// The "last bank" depends on whether the half override is active.
// Assumes BANKS16 is a power of two between 2 and 32.
module prg_bank_select
    import prg_xlat_pkg::*;
#(
    parameter int BANKS16 = 16,
    localparam int BW     = $clog2(BANKS16)
) (
    input  logic [1:0]    ctrl_mode,
    input  logic [4:0]    prg_bank,
    input  logic          upper_half,
    input  logic          ovr_active,
    output logic [BW-1:0] inner_bank
);

    localparam logic [4:0] LAST_FULL = 5'(BANKS16 - 1);
    localparam logic [4:0] LAST_HALF = 5'(BANKS16 / 2 - 1);

    logic [4:0] last_bank;
    logic [4:0] raw_bank;

    // Pick the fixed last bank according to the override state.
    always_comb begin
        last_bank = ovr_active ? LAST_HALF : LAST_FULL;
    end

    // Mode multiplexer producing the unreduced bank number.
    always_comb begin
        unique case (bank_mode_e'(ctrl_mode))
            MODE_W32A, MODE_W32B: raw_bank = {prg_bank[4:1], upper_half};
            MODE_FIX_LOW:         raw_bank = upper_half ? {1'b0, prg_bank[3:0]} : 5'd0;
            MODE_FIX_HIGH:        raw_bank = upper_half ? last_bank : {1'b0, prg_bank[3:0]};
            default:              raw_bank = 5'd0;
        endcase
    end

    // Reduce modulo the power-of-two bank count.
    always_comb begin
        inner_bank = BW'(raw_bank);
    end

endmodule

// File: rtl/prg_outer_map.sv
// Half-ROM override mapping.
// For ROMs larger than 8 banks, an enabled override keeps the low bits of the
// bank number and replaces the top bit with the selected half.
// For small ROMs the override is absent and the bank passes through unchanged.
// Assumes BANKS16 is a power of two between 2 and 32.
module prg_outer_map #(
    parameter int BANKS16 = 16,
    localparam int BW     = $clog2(BANKS16)
) (
    input  logic          ovr_req,
    input  logic          half_sel,
    input  logic [BW-1:0] inner_bank,
    output logic          ovr_active,
    output logic [BW-1:0] phys_bank
);

    generate
        if (BANKS16 > 8) begin : g_large
            // Override applies; modulo half plus the half base.
            always_comb begin
                ovr_active = ovr_req;
                phys_bank  = ovr_req ? {half_sel, inner_bank[BW-2:0]} : inner_bank;
            end
        end else begin : g_small
            logic unused_ok;
            // No override on small ROMs; the bank passes through.
            always_comb begin
                unused_ok  = ovr_req ^ half_sel;
                ovr_active = 1'b0;
                phys_bank  = inner_bank;
            end
        end
    endgenerate

endmodule

// File: rtl/prg_rom_bank_xlat.sv
// Program ROM bank translator, top level.
// Decodes the CPU address window, selects the ROM bank for the current mode,
// applies the half override and assembles the physical ROM address.
// Also produces the work RAM select and offset.
// With REG_OUT=1, all outputs pass through one register stage that has a
// synchronous active-low reset.
// Assumes BANKS16 is a power of two between 2 and 32.
module prg_rom_bank_xlat #(
    parameter int BANKS16 = 16,
    parameter bit REG_OUT = 1'b1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [15:0]                  cpu_addr,
    input  logic [1:0]                   ctrl_mode,
    input  logic [4:0]                   prg_bank,
    output logic                         rom_sel,
    output logic [$clog2(BANKS16)+13:0]  rom_addr,
    output logic                         ram_sel,
    output logic [12:0]                  ram_offset
);

    localparam int BW     = $clog2(BANKS16);
    localparam int ROM_AW = BW + 14;

    logic          rom_hit;
    logic          ram_hit;
    logic          upper_half;
    logic          ovr_active;
    logic [BW-1:0] inner_bank;
    logic [BW-1:0] phys_bank;

    logic              c_rom_sel;
    logic [ROM_AW-1:0] c_rom_addr;
    logic              c_ram_sel;
    logic [12:0]       c_ram_offset;

    prg_window_decode u_decode (
        .cpu_addr   (cpu_addr),
        .rom_hit    (rom_hit),
        .ram_hit    (ram_hit),
        .upper_half (upper_half)
    );

    prg_bank_select #(.BANKS16(BANKS16)) u_select (
        .ctrl_mode  (ctrl_mode),
        .prg_bank   (prg_bank),
        .upper_half (upper_half),
        .ovr_active (ovr_active),
        .inner_bank (inner_bank)
    );

    prg_outer_map #(.BANKS16(BANKS16)) u_outer (
        .ovr_req    (prg_bank[4]),
        .half_sel   (prg_bank[3]),
        .inner_bank (inner_bank),
        .ovr_active (ovr_active),
        .phys_bank  (phys_bank)
    );

    // Assemble the next output values, zeroed outside their windows.
    always_comb begin
        c_rom_sel    = rom_hit;
        c_rom_addr   = rom_hit ? {phys_bank, cpu_addr[13:0]} : '0;
        c_ram_sel    = ram_hit;
        c_ram_offset = ram_hit ? cpu_addr[12:0] : 13'd0;
    end

    generate
        if (REG_OUT) begin : g_reg
            // Output register stage with synchronous active-low reset.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    rom_sel    <= 1'b0;
                    rom_addr   <= '0;
                    ram_sel    <= 1'b0;
                    ram_offset <= 13'd0;
                end else begin
                    rom_sel    <= c_rom_sel;
                    rom_addr   <= c_rom_addr;
                    ram_sel    <= c_ram_sel;
                    ram_offset <= c_ram_offset;
                end
            end
        end else begin : g_comb
            logic unused_clk;
            // Combinational pass-through of the assembled outputs.
            always_comb begin
                unused_clk = clk ^ rst_n;
                rom_sel    = c_rom_sel;
                rom_addr   = c_rom_addr;
                ram_sel    = c_ram_sel;
                ram_offset = c_ram_offset;
            end
        end
    endgenerate

endmodule

// File: rtl/prg_rom_bank_xlat_chk.sv
// Property checker for the program ROM bank translator, attached by bind.
// It delays the inputs by one cycle when REG_OUT=1, so that every property
// compares the outputs with the inputs that produced them.
module prg_rom_bank_xlat_chk #(
    parameter int BANKS16 = 16,
    parameter bit REG_OUT = 1'b1,
    localparam int ROM_AW = $clog2(BANKS16) + 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic [15:0]       cpu_addr,
    input logic [1:0]        ctrl_mode,
    input logic [4:0]        prg_bank,
    input logic              rom_sel,
    input logic [ROM_AW-1:0] rom_addr,
    input logic              ram_sel,
    input logic [12:0]       ram_offset
);

    localparam bit BIG = (BANKS16 > 8);

    logic        past_ok;
    logic [15:0] q_addr;
    logic [1:0]  q_mode;
    logic [4:0]  q_bank;

    // Track whether the previous edge was outside reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // One-cycle copy of the inputs for the registered variant.
    always_ff @(posedge clk) begin
        q_addr <= cpu_addr;
        q_mode <= ctrl_mode;
        q_bank <= prg_bank;
    end

    logic        valid;
    logic [15:0] a_addr;
    logic [1:0]  a_mode;
    logic [4:0]  a_bank;
    logic        a_ovr;

    always_comb begin
        valid  = REG_OUT ? past_ok : 1'b1;
        a_addr = REG_OUT ? q_addr : cpu_addr;
        a_mode = REG_OUT ? q_mode : ctrl_mode;
        a_bank = REG_OUT ? q_bank : prg_bank;
        a_ovr  = BIG && a_bank[4];
    end

    assert_sel_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> !(rom_sel && ram_sel));

    assert_rom_window_R1: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (rom_sel == a_addr[15]));

    assert_ram_offset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && ram_sel) |-> (ram_offset == a_addr[12:0]));

    assert_unsel_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !rom_sel |-> (rom_addr == '0));

    assert_byte_offset_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && rom_sel) |-> (rom_addr[13:0] == a_addr[13:0]));

    assert_w32_low_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && rom_sel && !a_mode[1]) |-> (rom_addr[14] == a_addr[14]));

    assert_fixed_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && rom_sel && a_mode == 2'd2 && !a_addr[14] && !a_ovr)
        |-> (rom_addr[ROM_AW-1:14] == '0));

    assert_fixed_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && rom_sel && a_mode == 2'd3 && a_addr[14] && !a_ovr)
        |-> (rom_addr[ROM_AW-1:14] == '1));

    assert_half_base_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && rom_sel && a_ovr) |-> (rom_addr[ROM_AW-1] == a_bank[3]));

endmodule

bind prg_rom_bank_xlat prg_rom_bank_xlat_chk #(
    .BANKS16 (BANKS16),
    .REG_OUT (REG_OUT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_addr   (cpu_addr),
    .ctrl_mode  (ctrl_mode),
    .prg_bank   (prg_bank),
    .rom_sel    (rom_sel),
    .rom_addr   (rom_addr),
    .ram_sel    (ram_sel),
    .ram_offset (ram_offset)
);

// File: tb/prg_rom_bank_xlat_test.sv
// Bench for the program ROM bank translator: a vector table on a registered
// 16-bank instance, then directed reset, latency and small-ROM cases.
module prg_rom_bank_xlat_test;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [3:0]  rq;
        logic [15:0] a;
        logic [1:0]  m;
        logic [4:0]  b;
        logic        rs;
        logic        ms;
        logic [17:0] ra;
        logic [12:0] ro;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{4'd3, 16'h8123, 2'd0, 5'h06, 1'b1, 1'b0, 18'h18123, 13'h0000}, // R3 lower
        '{4'd3, 16'hC456, 2'd1, 5'h07, 1'b1, 1'b0, 18'h1C456, 13'h0000}, // R3 upper
        '{4'd4, 16'h8001, 2'd2, 5'h05, 1'b1, 1'b0, 18'h00001, 13'h0000}, // R4 fixed 0
        '{4'd4, 16'hFFFF, 2'd2, 5'h05, 1'b1, 1'b0, 18'h17FFF, 13'h0000}, // R4 switched
        '{4'd5, 16'h9000, 2'd3, 5'h0A, 1'b1, 1'b0, 18'h29000, 13'h0000}, // R5 switched
        '{4'd5, 16'hC000, 2'd3, 5'h02, 1'b1, 1'b0, 18'h3C000, 13'h0000}, // R5 last 15
        '{4'd7, 16'hC010, 2'd3, 5'h10, 1'b1, 1'b0, 18'h1C010, 13'h0000}, // R7 last 7
        '{4'd7, 16'hE000, 2'd3, 5'h18, 1'b1, 1'b0, 18'h3E000, 13'h0000}, // R7 7+8
        '{4'd7, 16'h8200, 2'd2, 5'h18, 1'b1, 1'b0, 18'h20200, 13'h0000}, // R7 0+8
        '{4'd4, 16'h8200, 2'd2, 5'h08, 1'b1, 1'b0, 18'h00200, 13'h0000}, // R4 no override
        '{4'd1, 16'h6ABC, 2'd0, 5'h00, 1'b0, 1'b1, 18'h00000, 13'h0ABC}, // R1 RAM
        '{4'd1, 16'h7FFF, 2'd0, 5'h00, 1'b0, 1'b1, 18'h00000, 13'h1FFF}, // R1 RAM top
        '{4'd1, 16'h5FFF, 2'd0, 5'h00, 1'b0, 1'b0, 18'h00000, 13'h0000}, // R1 neither
        '{4'd1, 16'h0000, 2'd3, 5'h1F, 1'b0, 1'b0, 18'h00000, 13'h0000}, // R1 neither
        '{4'd2, 16'hA5A5, 2'd3, 5'h03, 1'b1, 1'b0, 18'h0E5A5, 13'h0000}, // R2 offset
        '{4'd3, 16'hBFFF, 2'd1, 5'h1F, 1'b1, 1'b0, 18'h3BFFF, 13'h0000}  // R3 with override
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] addr;
    logic [1:0]  mode;
    logic [4:0]  bank;

    logic        rs,   ms,   rs_s, ms_s;
    logic [17:0] ra;
    logic [16:0] ra_s;
    logic [12:0] ro,   ro_s;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    prg_rom_bank_xlat #(.BANKS16(16), .REG_OUT(1'b1)) uut (
        .clk (clk), .rst_n (rst_n), .cpu_addr (addr), .ctrl_mode (mode),
        .prg_bank (bank), .rom_sel (rs), .rom_addr (ra), .ram_sel (ms),
        .ram_offset (ro)
    );

    prg_rom_bank_xlat #(.BANKS16(8), .REG_OUT(1'b0)) uut_small (
        .clk (clk), .rst_n (rst_n), .cpu_addr (addr), .ctrl_mode (mode),
        .prg_bank (bank), .rom_sel (rs_s), .rom_addr (ra_s), .ram_sel (ms_s),
        .ram_offset (ro_s)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [15:0] a, input logic [1:0] m, input logic [4:0] b);
        @(negedge clk);
        addr = a;
        mode = m;
        bank = b;
    endtask

    initial begin
        rst_n = 1'b0;
        addr  = 16'h8000;
        mode  = 2'd0;
        bank  = 5'h00;
        repeat (2) @(posedge clk);
        #1;
        check("R9 reset rom_sel", 32'(rs), 32'd0);
        check("R9 reset rom_addr", 32'(ra), 32'd0);
        check("R9 reset ram_sel", 32'(ms), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].a, VECS[i].m, VECS[i].b);
            @(posedge clk);
            #1;
            check($sformatf("R%0d vec %0d rom_sel", VECS[i].rq, i), 32'(rs), 32'(VECS[i].rs));
            check($sformatf("R%0d vec %0d rom_addr", VECS[i].rq, i), 32'(ra), 32'(VECS[i].ra));
            check($sformatf("R%0d vec %0d ram_sel", VECS[i].rq, i), 32'(ms), 32'(VECS[i].ms));
            check($sformatf("R%0d vec %0d ram_offset", VECS[i].rq, i), 32'(ro), 32'(VECS[i].ro));
        end

        // R9: output holds the previous result until the next edge.
        drive(16'h6000, 2'd0, 5'h00);
        #1;
        check("R9 latency hold ram_sel", 32'(ms), 32'd0);
        check("R9 latency hold rom_sel", 32'(rs), 32'd1);
        @(posedge clk);
        #1;
        check("R9 latency update ram_sel", 32'(ms), 32'd1);

        // R9: a reset in mid-run clears the registered outputs.
        drive(16'hC000, 2'd3, 5'h02);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R9 midrun reset rom_sel", 32'(rs), 32'd0);
        check("R9 midrun reset rom_addr", 32'(ra), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // Small ROM instance (8 banks, combinational).
        drive(16'hC000, 2'd3, 5'h10);
        #1;
        check("R8 small last bank ignores bit4", 32'(ra_s), 32'h1C000);
        drive(16'h8000, 2'd2, 5'h18);
        #1;
        check("R8 small fixed bank 0 ignores bit4", 32'(ra_s), 32'h00000);
        check("R8 small rom_sel", 32'(rs_s), 32'd1);
        drive(16'h8000, 2'd3, 5'h0A);
        #1;
        check("R6 small wrap mode3", 32'(ra_s), 32'h08000);
        drive(16'hC000, 2'd0, 5'h1E);
        #1;
        check("R6 small wrap mode0", 32'(ra_s), 32'h1C000);
        drive(16'h7123, 2'd0, 5'h00);
        #1;
        check("R1 small ram_offset", 32'(ro_s), 32'h1123);
        check("R1 small ram_sel", 32'(ms_s), 32'd1);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule